// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous request port and an asynchronous EDO DRAM. Each accepted request carries a write flag, a flat word address, write data and byte enables. The controller turns the request into the row and column strobe sequence the memory needs. The upper address bits go out as the row while RAS is falling. The lower bits go out as the column while CAS is falling. Each byte enable drives its own CAS strobe.

After an access the row stays open. A later request to the same row is served with a new column strobe only, and RAS stays low. A request to another row, a refresh request, or too little time left in the maximum RAS low window closes the page and precharges before anything else happens. Reads are captured at the end of the CAS precharge. This relies on the extended data hold of EDO parts, so consecutive page reads overlap. Refresh is granted to an external sequencer only once the memory is closed and precharged.

All timing figures are parameters in whole clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: An accepted address is split so that its upper ROW_W bits appear on dram_addr in the cycle RAS falls, and its lower COL_W bits appear on dram_addr in the cycle the CAS strobes fall.
- R2: A request to the row already open is accepted at the end of the current CAS precharge, or while the page is held. It is served with a CAS strobe only, with RAS kept low, so a back-to-back same-row burst that fits in the RAS window opens the row once.
- R3: A request to a different row raises RAS, and RAS stays high for at least T_RP cycles before it falls for the new row.
- R4: Byte enable bit 0 selects dram_casl_n (low byte) and bit 1 selects dram_cash_n (high byte). When both lanes are used they fall and rise in the same cycle. An all-zero byte enable is treated as both lanes.
- R5: Every write is an early write. dram_we_n goes low, and dram_dq_out/dram_dq_oe carry the data, at least one cycle before CAS falls, and stay unchanged while CAS is low. Reads keep dram_we_n high and dram_dq_oe low.
- R6: Each CAS low pulse lasts exactly T_CAS cycles. Inside a page, CAS stays high at least T_CP+1 cycles between pulses. The first CAS of a page falls at least T_RCD+1 cycles after RAS, and CAS is low only while RAS is low.
- R7: Each read returns one rsp_valid pulse, in request order, in the cycle after its CAS precharge ends. rsp_rdata holds the stored bytes for the enabled lanes and zero for the disabled lanes.
- R8: RAS never stays low longer than T_RAS_MAX cycles. A page is closed early even when more same-row requests are waiting.
- R9: refresh_gnt rises only with RAS and both CAS strobes high, after at least T_RP cycles of RAS precharge. An open page is closed first. The grant holds while refresh_req is high and drops once it is released.
- R10: After reset RAS, both CAS strobes, dram_we_n and dram_oe_n are high, dram_dq_oe, rsp_valid and refresh_gnt are low, and req_ready is high.
- R11: While refresh_req is high, req_ready is low, so refresh takes priority over pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| refresh_req | input | 1 | Refresh sequencer wants the memory |
| refresh_gnt | output | 1 | Memory closed and handed to the sequencer |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Low-byte column strobe, active low |
| dram_cash_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The bench builds the controller with a 3-bit row and a 3-bit column, so random traffic hits the same row often and the whole array fits in a 64-word model. It uses T_RCD=3, T_CAS=2, T_CP=2, T_RP=3 and a RAS window of only 30 cycles. A same-row burst then hits the forced close after a handful of page accesses, while a three-access burst still fits in one page. The short precharge keeps row changes and refresh hand-offs frequent inside a short run.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    S_IDLE,    // RAS high, precharged
    S_OPEN,    // RAS low, row access wait
    S_COLSET,  // column, WE and data set up, CAS high
    S_CAS,     // CAS low
    S_CPRE,    // CAS precharge, read capture at its end
    S_HOLD,    // page open, waiting for a request
    S_PRE,     // RAS precharge
    S_REF      // memory handed to the refresh sequencer
  } edo_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // RAS-low cycles one page hit adds: setup cycle, CAS pulse, CAS precharge
  function automatic int hit_cycles(int t_cas, int t_cp);
    return 1 + t_cas + t_cp;
  endfunction

  // ras_cnt counts the cycles already spent low before the current one.
  // Accepting now costs the current cycle plus one full hit.
  function automatic bit page_has_room(int ras_cnt, int t_cas, int t_cp, int t_max);
    return (ras_cnt + 1 + hit_cycles(t_cas, t_cp)) <= t_max;
  endfunction

  function automatic logic [LANES-1:0] lanes_of(logic [LANES-1:0] be);
    return (be == '0) ? '1 : be;
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard
  import edo_ctrl_pkg::*;
#(
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_RAS_MAX = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic room
);
  localparam int CW = $clog2(T_RAS_MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!ras_low)                 cnt <= '0;
    else if (cnt != CW'(T_RAS_MAX))    cnt <= cnt + 1'b1;
  end

  assign room = page_has_room(int'(cnt), T_CAS, T_CP, T_RAS_MAX);

  // R8: the low window never reaches its limit
  p_ras_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (cnt < CW'(T_RAS_MAX)));
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture
  import edo_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap_en;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      else if (cap_en)
        rsp_rdata[g*LANE_W +: LANE_W] <= lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 7,
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 1250
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [ROW_W+COL_W-1:0]             req_addr,
  input  logic [15:0]                        req_wdata,
  input  logic [1:0]                         req_be,
  output logic                               rsp_valid,
  output logic [15:0]                        rsp_rdata,
  input  logic                               refresh_req,
  output logic                               refresh_gnt,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                               dram_ras_n,
  output logic                               dram_casl_n,
  output logic                               dram_cash_n,
  output logic                               dram_we_n,
  output logic                               dram_oe_n,
  output logic [15:0]                        dram_dq_out,
  output logic                               dram_dq_oe,
  input  logic [15:0]                        dram_dq_in
);
  localparam int AW    = ROW_W + COL_W;
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX  = max_of4(T_RCD, T_CAS, T_CP, T_RP);
  localparam int TW    = $clog2(TMAX + 1);

  edo_state_e state, nxt;

  logic [ROW_W-1:0]  req_row, cur_row;
  logic [COL_W-1:0]  req_col, cur_col;
  logic [LANES-1:0]  req_lanes, cur_lanes;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_we;
  logic [LANES-1:0]  cas_n;

  // named internal events
  logic          t_load, t_done, room, row_hit, decide, accept, cap_en;
  logic [TW-1:0] t_val;

  assign req_row   = req_addr[AW-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign req_lanes = lanes_of(req_be);
  assign row_hit   = (req_row == cur_row);
  assign decide    = (state == S_HOLD) || (state == S_CPRE && t_done);
  assign req_ready = !refresh_req && ((state == S_IDLE) || (decide && row_hit && room));
  assign accept    = req_valid && req_ready;
  assign cap_en    = (state == S_CPRE) && t_done && !cur_we;

  edo_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  edo_ras_guard #(.T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_low(!dram_ras_n), .room(room)
  );

  edo_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .lanes(cur_lanes),
    .dq_in(dram_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      S_IDLE: begin
        if (refresh_req) nxt = S_REF;
        else if (req_valid) begin
          nxt = S_OPEN; t_load = 1'b1; t_val = TW'(T_RCD - 1);
        end
      end
      S_OPEN:   if (t_done) nxt = S_COLSET;
      S_COLSET: begin nxt = S_CAS; t_load = 1'b1; t_val = TW'(T_CAS - 1); end
      S_CAS: begin
        if (t_done) begin nxt = S_CPRE; t_load = 1'b1; t_val = TW'(T_CP - 1); end
      end
      S_CPRE, S_HOLD: begin
        if (decide) begin
          if (accept) nxt = S_COLSET;
          else if (refresh_req || !room || req_valid) begin
            nxt = S_PRE; t_load = 1'b1; t_val = TW'(T_RP - 1);
          end else nxt = S_HOLD;
        end
      end
      S_PRE: if (t_done) nxt = S_IDLE;
      S_REF: begin
        if (!refresh_req) begin nxt = S_PRE; t_load = 1'b1; t_val = TW'(T_RP - 1); end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur_row     <= '0;
      cur_col     <= '0;
      cur_lanes   <= '0;
      cur_wdata   <= '0;
      cur_we      <= 1'b0;
      cas_n       <= '1;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      refresh_gnt <= 1'b0;
    end else begin
      state       <= nxt;
      refresh_gnt <= (nxt == S_REF);
      if (accept) begin
        cur_row   <= req_row;
        cur_col   <= req_col;
        cur_lanes <= req_lanes;
        cur_wdata <= req_wdata;
        cur_we    <= req_write;
      end
      if (state == S_IDLE && nxt == S_OPEN) begin
        dram_addr  <= PIN_W'(req_row);
        dram_ras_n <= 1'b0;
      end
      if (nxt == S_COLSET && state != S_COLSET) begin
        dram_addr   <= PIN_W'(accept ? req_col : cur_col);
        dram_we_n   <= !(accept ? req_write : cur_we);
        dram_oe_n   <=  (accept ? req_write : cur_we);
        dram_dq_oe  <=  (accept ? req_write : cur_we);
        dram_dq_out <=  (accept ? req_wdata : cur_wdata);
      end
      if (state == S_COLSET) cas_n <= ~cur_lanes;
      if (state == S_CAS && nxt == S_CPRE) cas_n <= '1;
      if (nxt == S_PRE) begin
        dram_ras_n <= 1'b1;
        dram_we_n  <= 1'b1;
        dram_oe_n  <= 1'b1;
        dram_dq_oe <= 1'b0;
      end
    end
  end

  assign dram_casl_n = cas_n[0];
  assign dram_cash_n = cas_n[1];

  // R6: column strobes only inside an open row
  p_cas_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_casl_n || !dram_cash_n) |-> !dram_ras_n);
  // R5: WE and address settled before the strobe edge
  p_early_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_casl_n) || $fell(dram_cash_n)) |-> ($stable(dram_we_n) && $stable(dram_addr)));
  // R4: lanes used together move together
  p_lanes_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_casl_n && !dram_cash_n) |-> ($fell(dram_casl_n) == $fell(dram_cash_n)));
  // R9: grant only with the memory quiet
  p_gnt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_gnt |-> (dram_ras_n && dram_casl_n && dram_cash_n));
  // R11: refresh blocks new requests
  p_ref_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> !req_ready);
  // R7: read data follows a completed strobe
  p_rsp_after_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(dram_casl_n) && $past(dram_cash_n)));
endmodule

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb_top;
  localparam int RW = 3, CW = 3, AW = RW + CW;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3, T_RAS_MAX = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dram_dq_in = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, refresh_gnt;
  logic [15:0] rsp_rdata, dram_dq_out;
  logic [2:0]  dram_addr;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #4 clk = ~clk;  // 125 MHz

  edo_page_ctrl #(.ROW_W(RW), .COL_W(CW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                  .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .refresh_req(refresh_req),
    .refresh_gnt(refresh_gnt), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench functions restating the requirements
  function automatic logic [1:0] exp_lanes(logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction
  function automatic logic [15:0] lane_mask(logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  logic [15:0] ref_mem [64];
  logic [15:0] dev_mem [64];
  int          q_addr[$];
  bit          q_wr[$];
  logic [1:0]  q_lanes[$];
  logic [15:0] q_wdata[$];
  logic [15:0] q_rd[$];

  // ---------------- memory model and strobe timing checks ----------------
  bit prev_ras = 1'b1, prev_we = 1'b1, first_in_page = 1'b0;
  logic [1:0] prev_cas = 2'b11;
  bit prev_gnt = 1'b0;
  int ras_low_run = 0, ras_high_run = 1000, cas_low_run = 0, cas_high_run = 1000;
  int since_ras = 0, ras_falls = 0;
  logic [RW-1:0] row_lat = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] cas_now;
      cas_now = {dram_cash_n, dram_casl_n};
      if (prev_ras && !dram_ras_n) begin
        chk(ras_high_run >= T_RP, "R3", "RAS precharge", ras_high_run, T_RP);
        row_lat = dram_addr[RW-1:0];
        ras_falls++;
        first_in_page = 1'b1;
        since_ras = 0;
      end
      if (!prev_ras && dram_ras_n)
        chk(ras_low_run <= T_RAS_MAX, "R8", "RAS low run", ras_low_run, T_RAS_MAX);
      if (prev_cas == 2'b11 && cas_now != 2'b11) begin
        if (q_addr.size() == 0) chk(0, "R1", "strobe without request", cas_now, 0);
        else begin
          int a; bit w; logic [1:0] l; logic [15:0] d; int idx;
          a = q_addr.pop_front(); w = q_wr.pop_front();
          l = q_lanes.pop_front(); d = q_wdata.pop_front();
          idx = {row_lat, dram_addr[CW-1:0]};
          chk(idx == a, "R1", "row/col address", idx, a);
          chk(~cas_now == l, "R4", "lane strobes", ~cas_now, l);
          chk(dram_we_n == !w, "R5", "WE level", dram_we_n, !w);
          chk(prev_we == dram_we_n, "R5", "WE set before CAS", prev_we, dram_we_n);
          if (w) begin
            chk(dram_dq_oe && ((dram_dq_out & lane_mask(l)) == (d & lane_mask(l))),
                "R5", "write data", dram_dq_out, d);
            dev_mem[idx] = (dev_mem[idx] & ~lane_mask(l)) | (dram_dq_out & lane_mask(l));
          end else begin
            chk(!dram_dq_oe, "R5", "read drive off", dram_dq_oe, 0);
            dram_dq_in <= dev_mem[idx];
          end
          if (first_in_page) chk(since_ras >= T_RCD + 1, "R6", "RAS to CAS", since_ras, T_RCD + 1);
          else chk(cas_high_run >= T_CP + 1, "R6", "CAS precharge", cas_high_run, T_CP + 1);
          first_in_page = 1'b0;
        end
      end
      if (prev_cas != 2'b11 && cas_now == 2'b11)
        chk(cas_low_run == T_CAS, "R6", "CAS width", cas_low_run, T_CAS);
      if (prev_cas != 2'b11 && cas_now != 2'b11 && cas_now != prev_cas)
        chk(0, "R4", "lanes split", cas_now, prev_cas);
      if (refresh_gnt && !prev_gnt)
        chk(dram_ras_n && cas_now == 2'b11 && ras_high_run >= T_RP, "R9", "grant precharge",
            ras_high_run, T_RP);
      if (rsp_valid) begin
        if (q_rd.size() == 0) chk(0, "R7", "unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = q_rd.pop_front();
          chk(rsp_rdata == e, "R7", "read data", rsp_rdata, e);
        end
      end
      if (!dram_ras_n) begin
        ras_low_run = prev_ras ? 1 : ras_low_run + 1; ras_high_run = 0; since_ras++;
      end else begin
        ras_high_run++; ras_low_run = 0;
      end
      if (cas_now != 2'b11) begin
        cas_low_run = (prev_cas == 2'b11) ? 1 : cas_low_run + 1; cas_high_run = 0;
      end else begin
        cas_high_run++; cas_low_run = 0;
      end
      prev_ras = dram_ras_n; prev_cas = cas_now; prev_we = dram_we_n; prev_gnt = refresh_gnt;
    end
  end

  // ---------------- stimulus ----------------
  // called at a negedge; returns at a negedge with valid dropped
  task automatic issue(input bit w, input int a, input logic [15:0] d, input logic [1:0] be);
    bit acc;
    logic [1:0] l;
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d; req_be = be;
    forever begin
      #1 acc = req_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    l = exp_lanes(be);
    q_addr.push_back(a); q_wr.push_back(w); q_lanes.push_back(l); q_wdata.push_back(d);
    if (w) ref_mem[a] = (ref_mem[a] & ~lane_mask(l)) | (d & lane_mask(l));
    else   q_rd.push_back(ref_mem[a] & lane_mask(l));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_addr.size() != 0 || q_rd.size() != 0) @(negedge clk);
    repeat (T_RAS_MAX + 10) @(negedge clk);
  endtask

  task automatic do_refresh();
    int waited = 0;
    refresh_req = 1'b1;
    #1 chk(!req_ready, "R11", "ready under refresh", req_ready, 0);
    while (!refresh_gnt && waited < 200) begin @(negedge clk); waited++; end
    chk(refresh_gnt, "R9", "grant reached", refresh_gnt, 1);
    chk(dram_ras_n, "R9", "page closed at grant", dram_ras_n, 1);
    repeat (4) @(negedge clk);
    chk(refresh_gnt, "R9", "grant held", refresh_gnt, 1);
    refresh_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(!refresh_gnt, "R9", "grant released", refresh_gnt, 0);
  endtask

  initial begin
    int base, prev_row;
    for (int i = 0; i < 64; i++) begin ref_mem[i] = '0; dev_mem[i] = '0; end
    void'($urandom(32'h1ed0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n, "R10",
        "strobes idle", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rsp_valid && !refresh_gnt, "R10", "outputs quiet",
        {dram_dq_oe, rsp_valid, refresh_gnt}, 0);
    chk(req_ready, "R10", "ready after reset", req_ready, 1);

    // R2: short same-row burst opens the row once
    base = ras_falls;
    for (int c = 0; c < 3; c++) issue(1, (2 << CW) | c, 16'h1100 + 16'(c), 2'b11);
    drain();
    chk(ras_falls - base == 1, "R2", "row opens for 3-hit burst", ras_falls - base, 1);

    // R4/R7: byte lanes and a zero enable
    issue(1, 9, 16'hAAAA, 2'b11);
    issue(1, 9, 16'h1234, 2'b01);
    issue(1, 9, 16'h5678, 2'b10);
    issue(0, 9, 16'h0, 2'b11);      // expect 16'h5634
    issue(0, 9, 16'h0, 2'b01);      // high lane zero
    issue(1, 10, 16'hBEEF, 2'b00);  // zero enable -> both lanes
    issue(0, 10, 16'h0, 2'b10);
    drain();

    // R3: row change closes and reopens
    base = ras_falls;
    issue(1, (1 << CW) | 3, 16'hC0DE, 2'b11);
    issue(0, (4 << CW) | 3, 16'h0, 2'b11);
    drain();
    chk(ras_falls - base == 2, "R3", "row change reopens", ras_falls - base, 2);

    // R8: long same-row burst is split by the RAS window
    base = ras_falls;
    for (int c = 0; c < 12; c++) issue(0, (5 << CW) | (c % 8), 16'h0, 2'b11);
    drain();
    chk(ras_falls - base >= 2, "R8", "forced page close", ras_falls - base, 2);

    // R9: refresh with a page open
    issue(1, (6 << CW) | 1, 16'h7777, 2'b11);
    repeat (T_RCD + T_CAS + T_CP + 4) @(negedge clk);
    do_refresh();
    issue(0, (6 << CW) | 1, 16'h0, 2'b11);
    drain();

    // random traffic
    prev_row = 0;
    for (int n = 0; n < 300; n++) begin
      int r, row, col;
      r = int'($urandom() & 32'hffff);
      row = (r[0]) ? prev_row : int'($urandom() % 8);
      col = int'($urandom() % 8);
      prev_row = row;
      if ((r % 25) == 0) do_refresh();
      issue(r[1], (row << CW) | col, 16'($urandom()), 2'($urandom()));
    end
    drain();
    chk(q_rd.size() == 0, "R7", "all reads answered", q_rd.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule